// File: doc/BRIEF.md
# Indexed Literal Offset Data Address Generator

This block forms the 12-bit data-memory address for the byte and bit instructions of an 8-bit microcontroller core. It takes the 8-bit file operand from the instruction word, the bit that chooses between the access bank and a banked page, a switch that turns on the extended instruction set, a 4-bit bank register and a 12-bit pointer register. It returns one registered address per request, so the address is settled before the read-modify-write cycle that follows.

With the extended set off, an access-bank operand names a fixed location. Low operands land at the bottom of data memory, and high operands land in the top page, where the special function registers sit. A banked operand is appended to the bank register. With the extended set on, a low access-bank operand stops being a location. It becomes an unsigned offset that is added to the pointer register, which gives stack-frame addressing for compiled, re-entrant code. High access-bank operands and banked operands keep their usual meaning. The destination-select bit from the instruction is not used here. It is delayed by the same stage so that it stays aligned with its address.

The same mapping serves every byte-oriented and bit-oriented instruction format, because the block only sees the operand, the access bit and the mode switch.

Top module: `ila_addr_gen`

## Requirements
- R1: With the extended set on, the access bit at 0 and the operand at or below 0x5F, the address is (pointer + operand) and the indexed flag is 1.
- R2: With the extended set on, the access bit at 0 and the operand above 0x5F, the address follows the access-bank mapping of R3 and the indexed flag is 0.
- R3: With the extended set off and the access bit at 0, operands 0x00 to 0x5F map to addresses 0x000 to 0x05F, operands 0x60 to 0xFF map to 0xF60 to 0xFFF, and the indexed flag is 0.
- R4: With the access bit at 1, the address is the bank register in bits 11:8 and the operand in bits 7:0, in both modes, and the indexed flag is 0.
- R5: With the pointer register at zero, indexed addressing of operands 0x00 to 0x5F gives the same addresses as the access-bank mapping.
- R6: The destination-select bit is delivered unchanged, in the same cycle as the address it came with, in both modes.
- R7: The pointer-plus-offset sum wraps modulo 4096.
- R8: The address, the valid flag, the indexed flag and the destination bit are updated on the rising clock edge one cycle after the request. The valid output copies the request valid input. A synchronous active-high reset clears all four outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld_i | input | 1 | Request valid |
| acc_sel_i | input | 1 | 0 = access bank, 1 = banked page |
| ext_en_i | input | 1 | Extended instruction set enabled |
| dest_i | input | 1 | Destination-select bit from the instruction |
| opnd_i | input | 8 | File operand / literal offset |
| bank_i | input | 4 | Bank register value |
| ptr_i | input | 12 | Pointer register value |
| addr_o | output | 12 | Registered data address |
| vld_o | output | 1 | Registered request valid |
| indexed_o | output | 1 | Address came from pointer plus offset |
| dest_o | output | 1 | Registered destination-select bit |

## Verification
The bench uses the default parameters: an 8-bit operand, a 4-bit bank register and a 12-bit data space. At that size every operand can be swept against both access-bit values and both mode settings. The sweep runs under four pointer values: zero, a mid value, a value near the top of memory that forces the sum to wrap, and all ones. Together these reach every branch of the mapping, the 0x5F/0x60 window edge, the zero-pointer equivalence case and the modulo-4096 carry.

// File: rtl/ila_pkg.sv
package ila_pkg;

    localparam int OPND_W = 8;
    localparam int BANK_W = 4;
    localparam int ADDR_W = OPND_W + BANK_W;
    localparam int HIGH_W = ADDR_W - OPND_W;
    localparam logic [OPND_W-1:0] OFFS_MAX = 8'h5F;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OPND_W-1:0] opnd_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        MAP_ACCESS  = 2'd0,
        MAP_BANKED  = 2'd1,
        MAP_INDEXED = 2'd2
    } map_kind_t;

    typedef struct packed {
        logic  vld;
        logic  acc;
        logic  ext;
        logic  dest;
        opnd_t opnd;
        bank_t bank;
        addr_t ptr;
    } req_t;

    typedef struct packed {
        logic  vld;
        logic  indexed;
        logic  dest;
        addr_t addr;
    } resp_t;

    function automatic logic in_low_window(opnd_t o);
        return o <= OFFS_MAX;
    endfunction

endpackage

// File: rtl/ila_mode_sel.sv
module ila_mode_sel
    import ila_pkg::*;
(
    input  req_t      req_i,
    output map_kind_t kind_o
);
    always_comb begin
        if (req_i.acc)
            kind_o = MAP_BANKED;
        else if (req_i.ext && in_low_window(req_i.opnd))
            kind_o = MAP_INDEXED;
        else
            kind_o = MAP_ACCESS;
    end
endmodule

// File: rtl/ila_access_map.sv
module ila_access_map
    import ila_pkg::*;
#(
    parameter int OW = OPND_W,
    parameter int AW = ADDR_W,
    localparam int UW = AW - OW
) (
    input  logic [OW-1:0] opnd_i,
    output logic [AW-1:0] addr_o
);
    logic low;
    assign low = (opnd_i <= OFFS_MAX);
    assign addr_o[OW-1:0] = opnd_i;

    for (genvar i = 0; i < UW; i++) begin : g_fill
        assign addr_o[OW+i] = ~low;
    end
endmodule

// File: rtl/ila_index_add.sv
module ila_index_add
    import ila_pkg::*;
#(
    parameter int OW = OPND_W,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [OW-1:0] offs_i,
    output logic [AW-1:0] addr_o
);
    // Sum is truncated to AW bits, which gives the modulo wrap.
    assign addr_o = ptr_i + {{(AW-OW){1'b0}}, offs_i};
endmodule

// File: rtl/ila_out_reg.sv
module ila_out_reg
    import ila_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  resp_t d_i,
    output resp_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
    end

    // R8: a reset cycle leaves every output field cleared
    a_r8_reset_clears: assert property (@(posedge clk) rst |=> (q_o == '0))
        else $error("reset did not clear output stage");
endmodule

// File: rtl/ila_addr_gen.sv
module ila_addr_gen
    import ila_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_vld_i,
    input  logic        acc_sel_i,
    input  logic        ext_en_i,
    input  logic        dest_i,
    input  logic [7:0]  opnd_i,
    input  logic [3:0]  bank_i,
    input  logic [11:0] ptr_i,
    output logic [11:0] addr_o,
    output logic        vld_o,
    output logic        indexed_o,
    output logic        dest_o
);
    req_t      req;
    map_kind_t kind;
    addr_t     acc_addr, idx_addr, bnk_addr;
    resp_t     resp_d, resp_q;

    assign req = '{vld: req_vld_i, acc: acc_sel_i, ext: ext_en_i, dest: dest_i,
                   opnd: opnd_i, bank: bank_i, ptr: ptr_i};

    ila_mode_sel u_sel (.req_i(req), .kind_o(kind));

    ila_access_map #(.OW(OPND_W), .AW(ADDR_W)) u_acc (
        .opnd_i(req.opnd), .addr_o(acc_addr));

    ila_index_add #(.OW(OPND_W), .AW(ADDR_W)) u_idx (
        .ptr_i(req.ptr), .offs_i(req.opnd), .addr_o(idx_addr));

    assign bnk_addr = {req.bank, req.opnd};

    always_comb begin
        resp_d.vld     = req.vld;
        resp_d.dest    = req.dest;
        resp_d.indexed = (kind == MAP_INDEXED);
        unique case (kind)
            MAP_BANKED:  resp_d.addr = bnk_addr;
            MAP_INDEXED: resp_d.addr = idx_addr;
            default:     resp_d.addr = acc_addr;
        endcase
    end

    ila_out_reg u_oreg (.clk(clk), .rst(rst), .d_i(resp_d), .q_o(resp_q));

    assign addr_o    = resp_q.addr;
    assign vld_o     = resp_q.vld;
    assign indexed_o = resp_q.indexed;
    assign dest_o    = resp_q.dest;

    a_r1_indexed_sum: assert property (@(posedge clk) disable iff (rst)
        (ext_en_i && !acc_sel_i && opnd_i <= 8'h5F)
        |=> (indexed_o && addr_o == ($past(ptr_i) + {4'h0, $past(opnd_i)})))
        else $error("indexed address mismatch");

    a_r2_high_not_indexed: assert property (@(posedge clk) disable iff (rst)
        (ext_en_i && !acc_sel_i && opnd_i > 8'h5F)
        |=> (!indexed_o && addr_o == {4'hF, $past(opnd_i)}))
        else $error("high operand in extended mode misrouted");

    a_r3_plain_access: assert property (@(posedge clk) disable iff (rst)
        (!ext_en_i && !acc_sel_i)
        |=> (!indexed_o && addr_o[7:0] == $past(opnd_i)))
        else $error("plain access-bank mapping broken");

    a_r4_banked: assert property (@(posedge clk) disable iff (rst)
        acc_sel_i |=> (!indexed_o && addr_o == {$past(bank_i), $past(opnd_i)}))
        else $error("banked address mismatch");

    a_r6_dest_aligned: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dest_o == $past(dest_i)))
        else $error("destination bit not aligned");

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vld_o == $past(req_vld_i)))
        else $error("valid not delayed by one cycle");
endmodule

// File: tb/ila_addr_gen_test.sv
module ila_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0, acc_sel = 1'b0, ext_en = 1'b0, dest = 1'b0;
    logic [7:0]  opnd = '0;
    logic [3:0]  bank = '0;
    logic [11:0] ptr = '0;
    logic [11:0] addr;
    logic        vld, indexed, dest_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ila_addr_gen uut (
        .clk(clk), .rst(rst), .req_vld_i(req_vld), .acc_sel_i(acc_sel),
        .ext_en_i(ext_en), .dest_i(dest), .opnd_i(opnd), .bank_i(bank),
        .ptr_i(ptr), .addr_o(addr), .vld_o(vld), .indexed_o(indexed),
        .dest_o(dest_q));

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic apply(bit v, bit a, bit e, bit d, int op, int bk, int p);
        int exp_addr;
        bit exp_idx;
        string tag;
        @(negedge clk);
        req_vld = v; acc_sel = a; ext_en = e; dest = d;
        opnd = 8'(op); bank = 4'(bk); ptr = 12'(p);
        if (a) begin
            exp_addr = bk * 256 + op; exp_idx = 0; tag = "R4";
        end else if (e && op <= 95) begin
            exp_addr = (p + op) % 4096; exp_idx = 1;
            if (p == 0) tag = "R5";
            else if (p + op >= 4096) tag = "R7";
            else tag = "R1";
        end else begin
            exp_addr = (op <= 95) ? op : 3840 + op; exp_idx = 0;
            tag = e ? "R2" : "R3";
        end
        @(posedge clk);
        #1;
        check(tag, int'(addr), exp_addr);
        check({tag, " idx"}, int'(indexed), int'(exp_idx));
        check("R6 dest", int'(dest_q), int'(d));
        check("R8 valid", int'(vld), int'(v));
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check("R8 reset addr", int'(addr), 0);
        check("R8 reset valid", int'(vld), 0);
        check("R8 reset idx", int'(indexed), 0);
        check("R8 reset dest", int'(dest_q), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int pi = 0; pi < 4; pi++) begin
            int p;
            int bk;
            case (pi)
                0: begin p = 12'h000; bk = 0;  end
                1: begin p = 12'h123; bk = 5;  end
                2: begin p = 12'hFC0; bk = 15; end
                default: begin p = 12'hFFF; bk = 10; end
            endcase
            for (int e = 0; e < 2; e++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int op = 0; op < 256; op++) begin
                        apply(bit'((op % 7) != 3), bit'(a), bit'(e),
                              bit'((op ^ a) & 1), op, bk, p);
                    end
                end
            end
        end

        // R8: a reset in mid-run clears the outputs again
        apply(1, 1, 1, 1, 8'h42, 7, 12'h200);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 mid reset addr", int'(addr), 0);
        check("R8 mid reset valid", int'(vld), 0);
        finish_run();
    end
endmodule